// File: doc/BRIEF.md
# CAN FD Data-Phase Bit Timing Generator

This block produces the time base for the fast data phase of a CAN FD controller. A prescaler divides the module clock into time quanta. A segment counter then groups the quanta into bits and emits four single-cycle strobes for each bit: the start of the synchronisation quantum, the sample point, a next-bit strobe for transmit logic, and the end of the bit. Processing time after the sample point is zero. The next-bit strobe therefore fires on the clock that follows the sample point.

Three fields set the timing: a prescaler, a first segment covering propagation plus phase 1, and a second segment holding phase 2. These fields live in a configuration register. The register can be loaded only while the controller is in initialisation mode and configuration changes are enabled. While initialisation mode is active, both counters are held and no strobes appear. Timing begins at a bit boundary on the first cycle after release. A field combination whose bit length lies outside 4 to 25 quanta is clamped into that range, and an error flag is raised.

Top module: `canfd_dbit_timer`

## Requirements
- R1: Outside initialisation, one quantum lasts (prescaler field + 1) clock cycles. `tqTick` is high on the last cycle of every quantum, and exactly once per quantum.
- R2: A bit lasts (seg1 field + seg2 field + 3) quanta when that sum lies within 4..25. `bitEnd` is high on the last clock cycle of the bit.
- R3: `syncStart` is high on the first clock cycle of every bit. The synchronisation segment is one quantum, which is quantum index 0 of the bit.
- R4: `samplePt` is high on the last clock cycle of quantum index (effective seg1 + 1) within the bit.
- R5: `nextBitStrobe` is high on the clock cycle right after each `samplePt`.
- R6: A configuration write (`cfgWrEn`) takes effect on the next clock edge only when `initMode` and `cfgChangeEn` are both 1. Otherwise the write is ignored, and the read-back fields `cfgPresc`, `cfgSeg1`, `cfgSeg2` keep their values.
- R7: While `initMode` is 1, all strobes and `tqTick` stay low. The cycle right after `initMode` falls is the first cycle of a bit.
- R8: If the sum seg1 + seg2 + 3 is below 4, `cfgError` is 1 and the bit is lengthened to 4 quanta by raising seg2.
- R9: If the sum is above 25, `cfgError` is 1. Seg2 is limited to 22, and seg1 is then reduced so that the bit is 25 quanta. For example, seg1=31 with seg2=15 behaves as seg1=7 with seg2=15.
- R10: After reset the fields read prescaler 0, seg1 10 and seg2 3, `cfgError` is 0 and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| initMode | input | 1 | Initialisation mode; holds counters |
| cfgChangeEn | input | 1 | Configuration change enable |
| cfgWrEn | input | 1 | Configuration write strobe |
| wrPresc | input | 10 | Prescaler value to write |
| wrSeg1 | input | 5 | Seg1 (prop + phase 1) value to write |
| wrSeg2 | input | 4 | Seg2 (phase 2) value to write |
| cfgPresc | output | 10 | Stored prescaler field |
| cfgSeg1 | output | 5 | Stored seg1 field |
| cfgSeg2 | output | 4 | Stored seg2 field |
| cfgError | output | 1 | Stored bit length outside 4..25 quanta |
| tqTick | output | 1 | Last cycle of a quantum |
| syncStart | output | 1 | First cycle of a bit |
| samplePt | output | 1 | Sample point cycle |
| nextBitStrobe | output | 1 | Cycle after the sample point |
| bitEnd | output | 1 | Last cycle of a bit |

## Verification
The bench builds the block with its default field widths: a 10-bit prescaler, a 5-bit seg1 and a 4-bit seg2, with a legal range of 4 to 25 quanta. These widths let seg1 and seg2 express sums both below and far above the legal range, so both clamp directions can be exercised. They also allow a one-cycle quantum, in which the next-bit strobe coincides with the end of the bit. The full 1024-cycle quantum is also reachable, at a cost of a few thousand cycles.

// File: rtl/canfd_dbit_pkg.sv
package canfd_dbit_pkg;
  typedef struct packed {
    logic syncStart;
    logic samplePt;
    logic nextBit;
    logic bitEnd;
  } bitStrobes_t;
endpackage

// File: rtl/canfd_dbit_cfg.sv
// Guarded timing register plus range clamp of the segment fields.
module canfd_dbit_cfg #(
  parameter int PRESC_W   = 10,
  parameter int SEG1_W    = 5,
  parameter int SEG2_W    = 4,
  parameter int MIN_TQ    = 4,
  parameter int MAX_TQ    = 25,
  parameter int RST_PRESC = 0,
  parameter int RST_SEG1  = 10,
  parameter int RST_SEG2  = 3,
  parameter int QCNT_W    = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               initMode,
  input  logic               cfgChangeEn,
  input  logic               cfgWrEn,
  input  logic [PRESC_W-1:0] wrPresc,
  input  logic [SEG1_W-1:0]  wrSeg1,
  input  logic [SEG2_W-1:0]  wrSeg2,
  output logic [PRESC_W-1:0] cfgPresc,
  output logic [SEG1_W-1:0]  cfgSeg1,
  output logic [SEG2_W-1:0]  cfgSeg2,
  output logic               cfgError,
  output logic [QCNT_W-1:0]  samplePos,
  output logic [QCNT_W-1:0]  bitLast
);
  localparam int TOT_W = SEG1_W + 2;
  localparam logic [TOT_W-1:0] SUM_MAX = TOT_W'(MAX_TQ - 3);
  localparam logic [TOT_W-1:0] SUM_MIN = TOT_W'(MIN_TQ - 3);
  localparam logic [TOT_W-1:0] TQ_MAX  = TOT_W'(MAX_TQ);
  localparam logic [TOT_W-1:0] TQ_MIN  = TOT_W'(MIN_TQ);

  logic             wrAllowed;
  logic [TOT_W-1:0] rawTotal, s1Eff, s2Eff, posWide, lastWide;

  assign wrAllowed = cfgWrEn && initMode && cfgChangeEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgPresc <= PRESC_W'(RST_PRESC);
      cfgSeg1  <= SEG1_W'(RST_SEG1);
      cfgSeg2  <= SEG2_W'(RST_SEG2);
    end else if (wrAllowed) begin
      cfgPresc <= wrPresc;
      cfgSeg1  <= wrSeg1;
      cfgSeg2  <= wrSeg2;
    end
  end

  always_comb begin
    rawTotal = TOT_W'(cfgSeg1) + TOT_W'(cfgSeg2) + TOT_W'(3);
    s2Eff = TOT_W'(cfgSeg2);
    if (s2Eff > SUM_MAX) s2Eff = SUM_MAX;
    s1Eff = TOT_W'(cfgSeg1);
    if (s1Eff > SUM_MAX - s2Eff) s1Eff = SUM_MAX - s2Eff;
    if (s1Eff + s2Eff < SUM_MIN) s2Eff = SUM_MIN - s1Eff;
    posWide  = s1Eff + TOT_W'(1);
    lastWide = s1Eff + s2Eff + TOT_W'(2);
  end

  assign cfgError  = (rawTotal > TQ_MAX) || (rawTotal < TQ_MIN);
  assign samplePos = posWide[QCNT_W-1:0];
  assign bitLast   = lastWide[QCNT_W-1:0];
endmodule

// File: rtl/canfd_dbit_prescaler.sv
// Quantum divider: counts 0..presc, held at zero in init mode.
module canfd_dbit_prescaler #(
  parameter int PRESC_W = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               run,
  input  logic [PRESC_W-1:0] presc,
  output logic               tqTick,
  output logic               tqFirst
);
  logic [PRESC_W-1:0] preCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= '0;
    else if (!run)            preCnt <= '0;
    else if (preCnt == presc) preCnt <= '0;
    else                      preCnt <= preCnt + PRESC_W'(1);
  end

  assign tqTick  = run && (preCnt == presc);
  assign tqFirst = run && (preCnt == '0);
endmodule

// File: rtl/canfd_dbit_segctrl.sv
// Quantum counter within a bit and the per-bit strobe set.
module canfd_dbit_segctrl
  import canfd_dbit_pkg::*;
#(
  parameter int QCNT_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic              tqTick,
  input  logic              tqFirst,
  input  logic [QCNT_W-1:0] samplePos,
  input  logic [QCNT_W-1:0] bitLast,
  output bitStrobes_t       strobes
);
  logic [QCNT_W-1:0] qCnt;
  logic              nextBitQ;
  logic              sampleNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              qCnt <= '0;
    else if (!run)          qCnt <= '0;
    else if (tqTick) begin
      if (qCnt == bitLast)  qCnt <= '0;
      else                  qCnt <= qCnt + QCNT_W'(1);
    end
  end

  assign sampleNow = tqTick && (qCnt == samplePos);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nextBitQ <= 1'b0;
    else       nextBitQ <= sampleNow;
  end

  always_comb begin
    strobes.syncStart = tqFirst && (qCnt == '0);
    strobes.samplePt  = sampleNow;
    strobes.nextBit   = nextBitQ && run;
    strobes.bitEnd    = tqTick && (qCnt == bitLast);
  end
endmodule

// File: rtl/canfd_dbit_timer.sv
module canfd_dbit_timer
  import canfd_dbit_pkg::*;
#(
  parameter int PRESC_W = 10,
  parameter int SEG1_W  = 5,
  parameter int SEG2_W  = 4,
  parameter int MIN_TQ  = 4,
  parameter int MAX_TQ  = 25
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               initMode,
  input  logic               cfgChangeEn,
  input  logic               cfgWrEn,
  input  logic [PRESC_W-1:0] wrPresc,
  input  logic [SEG1_W-1:0]  wrSeg1,
  input  logic [SEG2_W-1:0]  wrSeg2,
  output logic [PRESC_W-1:0] cfgPresc,
  output logic [SEG1_W-1:0]  cfgSeg1,
  output logic [SEG2_W-1:0]  cfgSeg2,
  output logic               cfgError,
  output logic               tqTick,
  output logic               syncStart,
  output logic               samplePt,
  output logic               nextBitStrobe,
  output logic               bitEnd
);
  localparam int QCNT_W = $clog2(MAX_TQ + 1);

  logic              run, tqFirst;
  logic [QCNT_W-1:0] samplePos, bitLast;
  bitStrobes_t       strobes;

  assign run = !initMode;

  canfd_dbit_cfg #(
    .PRESC_W(PRESC_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W),
    .MIN_TQ(MIN_TQ), .MAX_TQ(MAX_TQ),
    .RST_PRESC(0), .RST_SEG1(10), .RST_SEG2(3), .QCNT_W(QCNT_W)
  ) uCfg (
    .clk(clk), .rstN(rstN), .initMode(initMode), .cfgChangeEn(cfgChangeEn),
    .cfgWrEn(cfgWrEn), .wrPresc(wrPresc), .wrSeg1(wrSeg1), .wrSeg2(wrSeg2),
    .cfgPresc(cfgPresc), .cfgSeg1(cfgSeg1), .cfgSeg2(cfgSeg2),
    .cfgError(cfgError), .samplePos(samplePos), .bitLast(bitLast)
  );

  canfd_dbit_prescaler #(.PRESC_W(PRESC_W)) uPre (
    .clk(clk), .rstN(rstN), .run(run), .presc(cfgPresc),
    .tqTick(tqTick), .tqFirst(tqFirst)
  );

  canfd_dbit_segctrl #(.QCNT_W(QCNT_W)) uSeg (
    .clk(clk), .rstN(rstN), .run(run), .tqTick(tqTick), .tqFirst(tqFirst),
    .samplePos(samplePos), .bitLast(bitLast), .strobes(strobes)
  );

  assign syncStart     = strobes.syncStart;
  assign samplePt      = strobes.samplePt;
  assign nextBitStrobe = strobes.nextBit;
  assign bitEnd        = strobes.bitEnd;
endmodule

// File: rtl/canfd_dbit_timer_chk.sv
module canfd_dbit_timer_chk #(
  parameter int PRESC_W = 10,
  parameter int SEG1_W  = 5,
  parameter int SEG2_W  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               initMode,
  input logic               cfgChangeEn,
  input logic               cfgWrEn,
  input logic [PRESC_W-1:0] cfgPresc,
  input logic [SEG1_W-1:0]  cfgSeg1,
  input logic [SEG2_W-1:0]  cfgSeg2,
  input logic               tqTick,
  input logic               syncStart,
  input logic               samplePt,
  input logic               nextBitStrobe,
  input logic               bitEnd
);
  a_r7_quiet_in_init: assert property (@(posedge clk) disable iff (!rstN)
    initMode |-> !(tqTick || syncStart || samplePt || nextBitStrobe || bitEnd));

  a_r5_next_after_sample: assert property (@(posedge clk) disable iff (!rstN)
    samplePt |=> (nextBitStrobe || initMode));

  a_r2_end_then_sync: assert property (@(posedge clk) disable iff (!rstN)
    bitEnd |=> (syncStart || initMode));

  a_r4_strobes_disjoint: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({syncStart, samplePt, bitEnd}));

  a_r6_write_locked: assert property (@(posedge clk) disable iff (!rstN)
    !(initMode && cfgChangeEn) |=> ($stable(cfgPresc) && $stable(cfgSeg1) && $stable(cfgSeg2)));

  a_r1_tick_in_quantum: assert property (@(posedge clk) disable iff (!rstN)
    (samplePt || bitEnd) |-> tqTick);

  logic unusedWr;
  assign unusedWr = cfgWrEn;
endmodule

bind canfd_dbit_timer canfd_dbit_timer_chk #(
  .PRESC_W(PRESC_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W)
) uChk (
  .clk(clk), .rstN(rstN), .initMode(initMode), .cfgChangeEn(cfgChangeEn),
  .cfgWrEn(cfgWrEn), .cfgPresc(cfgPresc), .cfgSeg1(cfgSeg1), .cfgSeg2(cfgSeg2),
  .tqTick(tqTick), .syncStart(syncStart), .samplePt(samplePt),
  .nextBitStrobe(nextBitStrobe), .bitEnd(bitEnd)
);

// File: tb/canfd_dbit_timer_test.sv
module canfd_dbit_timer_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic initMode = 1'b1, cfgChangeEn = 1'b0, cfgWrEn = 1'b0;
  logic [9:0] wrPresc = '0;
  logic [4:0] wrSeg1 = '0;
  logic [3:0] wrSeg2 = '0;
  logic [9:0] cfgPresc;
  logic [4:0] cfgSeg1;
  logic [3:0] cfgSeg2;
  logic cfgError, tqTick, syncStart, samplePt, nextBitStrobe, bitEnd;

  canfd_dbit_timer uut (.*);

  always #5 clk = ~clk;

  typedef struct { int kind; longint at; } ev_t;
  ev_t expQ[$];
  longint cyc = 0;
  int tests = 0, fails = 0;
  bit monEn = 0;
  int tickCnt = 0;
  string kindName [4] = '{"R3 syncStart", "R4 samplePt", "R5 nextBitStrobe", "R2 bitEnd"};

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // monitor: pop expected events as strobes appear
  always @(negedge clk) begin
    if (monEn) begin
      logic [3:0] seen;
      seen = {syncStart, samplePt, nextBitStrobe, bitEnd};
      if (tqTick) tickCnt++;
      for (int k = 0; k < 4; k++) begin
        if (seen[3-k]) begin
          if (expQ.size() == 0) check(0, kindName[k], cyc, -1);
          else begin
            ev_t e;
            e = expQ.pop_front();
            check(e.kind == k && e.at == cyc, kindName[k], cyc, e.at);
          end
        end
      end
    end
  end

  task automatic writeCfg(int p, int s1, int s2);
    @(posedge clk); #1;
    cfgWrEn = 1; wrPresc = 10'(p); wrSeg1 = 5'(s1); wrSeg2 = 4'(s2);
    @(posedge clk); #1;
    cfgWrEn = 0;
  endtask

  task automatic runBits(int p, int s1, int s2, int nBits, bit expErr, string errReq);
    int s1e, s2e, bitLen, qLen;
    longint base, stop;
    initMode = 1; cfgChangeEn = 1;
    writeCfg(p, s1, s2);
    cfgChangeEn = 0;
    @(negedge clk);
    check(cfgPresc == 10'(p) && cfgSeg1 == 5'(s1) && cfgSeg2 == 4'(s2), "R6 accepted write", cfgSeg1, s1);
    check(cfgError == expErr, errReq, cfgError, expErr);
    check(!(tqTick || syncStart || samplePt || nextBitStrobe || bitEnd), "R7 quiet in init", 1, 0);
    // effective segments per R2/R8/R9
    s2e = (s2 > 22) ? 22 : s2;
    s1e = (s1 > 22 - s2e) ? 22 - s2e : s1;
    if (s1e + s2e + 3 < 4) s2e = 1 - s1e;
    bitLen = s1e + s2e + 3;
    qLen = p + 1;
    @(posedge clk); #1;
    base = cyc;
    for (int b = 0; b < nBits; b++) begin
      longint bs, smp;
      bs = base + longint'(b) * bitLen * qLen;
      smp = bs + longint'(s1e + 2) * qLen - 1;
      expQ.push_back('{0, bs});
      expQ.push_back('{1, smp});
      expQ.push_back('{2, smp + 1});
      expQ.push_back('{3, bs + longint'(bitLen) * qLen - 1});
    end
    stop = base + longint'(nBits) * bitLen * qLen;
    tickCnt = 0;
    initMode = 0; monEn = 1;
    do begin @(posedge clk); #1; end while (cyc < stop);
    initMode = 1; monEn = 0;
    check(expQ.size() == 0, "R2 all bit events seen", expQ.size(), 0);
    expQ.delete();
    check(tickCnt == nBits * bitLen, "R1 quantum count", tickCnt, nBits * bitLen);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", cyc, 200000);
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    check(cfgPresc == 0 && cfgSeg1 == 10 && cfgSeg2 == 3, "R10 reset fields", cfgSeg1, 10);
    check(cfgError == 0, "R10 reset error flag", cfgError, 0);
    check(!(tqTick || syncStart || samplePt || nextBitStrobe || bitEnd), "R10 reset strobes", 1, 0);

    // R6: locked writes
    initMode = 1; cfgChangeEn = 0;
    writeCfg(5, 2, 2);
    @(negedge clk);
    check(cfgPresc == 0 && cfgSeg1 == 10 && cfgSeg2 == 3, "R6 ignored without change enable", cfgPresc, 0);
    initMode = 0; cfgChangeEn = 1;
    writeCfg(7, 1, 1);
    @(negedge clk);
    check(cfgPresc == 0 && cfgSeg1 == 10 && cfgSeg2 == 3, "R6 ignored outside init", cfgPresc, 0);
    initMode = 1; cfgChangeEn = 0;

    runBits(0, 10, 3, 3, 0, "R2 no error");
    runBits(3, 2, 1, 3, 0, "R2 no error");
    runBits(0, 4, 0, 3, 0, "R5 next with end");
    runBits(0, 0, 0, 4, 1, "R8 low error");
    runBits(1, 31, 15, 2, 1, "R9 high error");
    runBits(2, 19, 3, 2, 0, "R2 exact max");
    runBits(1023, 1, 0, 1, 0, "R1 wide prescaler");
    finishRun();
  end
endmodule